// File: doc/BRIEF.md
# Multi-Source Reset Pulse Sequencer

This block merges three reasons to hold a system in reset into one active-low reset line whose active phase is never shorter than a selectable minimum. The first two reasons are levels: a supply-low flag produced by an external comparator, and a manual push-button input that is low while pressed. The third is a single-cycle fault pulse from a watchdog window detector. While any level reason is present the reset stays asserted. Once the last level reason has gone, or after a fault pulse, the reset is stretched for a timeout picked from four lengths by a 2-bit select.

The push-button input passes through a two-stage synchronizer and a stability filter, so short low glitches are dropped and bounce on release cannot cut the stretch short. A status output tells the watchdog that reset is in force, so it can stop counting. A parameter chooses the pad style. Push-pull drives both levels. Open-drain drives the data bit low all the time and uses the output enable to pull the line low, relying on an external pull-up for the high level. The supply flag and the fault pulse are taken as synchronous to the clock.

Top module: `rst_pulse_seq`

## Requirements
- R1: While `rst_n` is low, `rst_active_o` is 1. After `rst_n` is released, with no cause present, `rst_active_o` stays 1 for exactly the selected timeout in clock samples, then drops to 0.
- R2: When `uv_flag_i` is 1 at a clock edge, `rst_active_o` is 1 after that edge, and it stays 1 for as long as the flag stays high.
- R3: If `mr_n_i` is held low for FILT_CYC cycles or more, `rst_active_o` rises FILT_CYC+3 clock edges after the input falls.
- R4: A low pulse on `mr_n_i` that lasts fewer than FILT_CYC cycles leaves `rst_active_o` at 0.
- R5: After the last level cause clears, `rst_active_o` stays 1 for exactly the selected timeout, counted from the first edge at which no level cause is seen.
- R6: A one-cycle `wd_fault_i` pulse while the block is idle holds `rst_active_o` at 1 for exactly the selected timeout.
- R7: A `wd_fault_i` pulse while the timeout is running restarts the full timeout from that edge.
- R8: If a level cause returns while the timeout is running, the count is dropped, and a full timeout starts again only when all level causes are gone.
- R9: `tmo_sel_i` encodes the timeout: 0 gives TMO0, 1 gives TMO1, 2 gives TMO2 and 3 gives TMO3 clock cycles.
- R10: With OD_MODE=0, `rst_oe_o` is always 1 and `rst_n_o` is the inverse of `rst_active_o`. With OD_MODE=1, `rst_n_o` is always 0 and `rst_oe_o` equals `rst_active_o`. In both styles, a line with a pull-up reads 1 exactly when `rst_active_o` is 0.
- R11: The push-button filter starts in the released (high) state after reset. A high glitch shorter than FILT_CYC cycles during a press does not start the timeout, and release stretches reset by FILT_CYC+2+timeout samples from the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| uv_flag_i | input | 1 | Supply-below-threshold flag, high active |
| mr_n_i | input | 1 | Manual reset push-button, low while pressed |
| wd_fault_i | input | 1 | Watchdog fault pulse, one cycle |
| tmo_sel_i | input | 2 | Timeout length select |
| rst_n_o | output | 1 | Reset pad data bit |
| rst_oe_o | output | 1 | Reset pad output enable |
| rst_active_o | output | 1 | Reset-in-force status for the watchdog |

## Verification
The hardest situation to reach is a cause arriving while the stretch is partway through its count, since the stretch only exists for a bounded window after a release. The stimulus releases the supply flag, waits a fixed number of cycles, and then injects either a fault pulse or a renewed flag inside that window. Push-button cases are placed at exactly FILT_CYC-1 and FILT_CYC cycles of low, and a short high bounce is placed inside a long press, so that both filter edges are exercised at their limits.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_TMO  = 2'd2
    } rps_state_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rps_mr_filter.sv
module rps_mr_filter #(
    parameter int unsigned FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n_i,
    output logic pressed_o
);
    localparam int unsigned FW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          flt;
        logic [FW-1:0] cnt;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d       = filt_q;
        filt_d.sync1 = mr_n_i;
        filt_d.sync2 = filt_q.sync1;
        if (filt_q.sync2 != filt_q.flt) begin
            if (filt_q.cnt == FW'(FILT_CYC - 1)) begin
                filt_d.flt = filt_q.sync2;
                filt_d.cnt = '0;
            end else begin
                filt_d.cnt = filt_q.cnt + 1'b1;
            end
        end else begin
            filt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '{sync1: 1'b1, sync2: 1'b1, flt: 1'b1, cnt: '0};
        end else begin
            filt_q <= filt_d;
        end
    end

    assign pressed_o = ~filt_q.flt;

endmodule

// File: rtl/rps_seq.sv
module rps_seq
    import rps_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic          fault_i,
    input  logic [CW-1:0] limit_i,
    output logic          active_o
);
    typedef struct packed {
        rps_state_e    state;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_HOLD: begin
                seq_d.cnt = '0;
                if (!lvl_i) seq_d.state = ST_TMO;
            end
            ST_TMO: begin
                if (lvl_i) begin
                    seq_d.state = ST_HOLD;
                    seq_d.cnt   = '0;
                end else if (fault_i) begin
                    seq_d.cnt   = '0;
                end else if (seq_q.cnt == limit_i - CW'(1)) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.cnt = '0;
                if (lvl_i)        seq_d.state = ST_HOLD;
                else if (fault_i) seq_d.state = ST_TMO;
                else              seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_HOLD, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active_o = (seq_q.state != ST_IDLE);

endmodule

// File: rtl/rps_out_drv.sv
module rps_out_drv #(
    parameter bit OD_MODE = 1'b0
) (
    input  logic active_i,
    output logic pad_o,
    output logic pad_oe_o
);
    generate
        if (OD_MODE) begin : g_open_drain
            assign pad_o    = 1'b0;
            assign pad_oe_o = active_i;
        end else begin : g_push_pull
            assign pad_o    = ~active_i;
            assign pad_oe_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rst_pulse_seq.sv
module rst_pulse_seq
    import rps_pkg::*;
#(
    parameter int unsigned FILT_CYC = 8,
    parameter int unsigned TMO0     = 14,
    parameter int unsigned TMO1     = 28,
    parameter int unsigned TMO2     = 50,
    parameter int unsigned TMO3     = 100,
    parameter bit          OD_MODE  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_flag_i,
    input  logic       mr_n_i,
    input  logic       wd_fault_i,
    input  logic [1:0] tmo_sel_i,
    output logic       rst_n_o,
    output logic       rst_oe_o,
    output logic       rst_active_o
);
    localparam int unsigned TMAX = max4(TMO0, TMO1, TMO2, TMO3);
    localparam int unsigned CW   = $clog2(TMAX + 1);

    logic          mr_pressed;
    logic          lvl_cause;
    logic [CW-1:0] limit;
    logic          active;

    rps_mr_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr_n_i    (mr_n_i),
        .pressed_o (mr_pressed)
    );

    assign lvl_cause = uv_flag_i | mr_pressed;

    always_comb begin
        unique case (tmo_sel_i)
            2'd0:    limit = CW'(TMO0);
            2'd1:    limit = CW'(TMO1);
            2'd2:    limit = CW'(TMO2);
            default: limit = CW'(TMO3);
        endcase
    end

    rps_seq #(.CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl_cause),
        .fault_i  (wd_fault_i),
        .limit_i  (limit),
        .active_o (active)
    );

    rps_out_drv #(.OD_MODE(OD_MODE)) u_drv (
        .active_i (active),
        .pad_o    (rst_n_o),
        .pad_oe_o (rst_oe_o)
    );

    assign rst_active_o = active;

endmodule

// File: rtl/rps_checker.sv
module rps_checker (
    input logic clk,
    input logic rst_n,
    input logic uv_flag_i,
    input logic wd_fault_i,
    input logic rst_n_o,
    input logic rst_oe_o,
    input logic rst_active_o
);
    AST_UV_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag_i |=> rst_active_o); // R2

    AST_FAULT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fault_i |=> rst_active_o); // R6

    AST_NO_RELEASE_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active_o) |-> (!$past(uv_flag_i) && !$past(wd_fault_i))); // R5

    AST_PAD_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active_o |-> (rst_oe_o && !rst_n_o)); // R10

    AST_PAD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_active_o |-> (!rst_oe_o || rst_n_o)); // R10

endmodule

bind rst_pulse_seq rps_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uv_flag_i    (uv_flag_i),
    .wd_fault_i   (wd_fault_i),
    .rst_n_o      (rst_n_o),
    .rst_oe_o     (rst_oe_o),
    .rst_active_o (rst_active_o)
);

// File: tb/test_rst_pulse_seq.sv
module test_rst_pulse_seq;
    localparam int FILT = 8;
    localparam int T0 = 14, T1 = 28, T2 = 50, T3 = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv = 1'b0;
    logic mr_n = 1'b1;
    logic wd = 1'b0;
    logic [1:0] sel = 2'd0;

    logic pp_d, pp_oe, pp_act;
    logic od_d, od_oe, od_act;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    rst_pulse_seq #(.FILT_CYC(FILT), .TMO0(T0), .TMO1(T1), .TMO2(T2), .TMO3(T3),
                    .OD_MODE(1'b0)) i_rst_pulse_seq (
        .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .mr_n_i(mr_n), .wd_fault_i(wd),
        .tmo_sel_i(sel), .rst_n_o(pp_d), .rst_oe_o(pp_oe), .rst_active_o(pp_act));

    rst_pulse_seq #(.FILT_CYC(FILT), .TMO0(T0), .TMO1(T1), .TMO2(T2), .TMO3(T3),
                    .OD_MODE(1'b1)) i_rst_pulse_seq_od (
        .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .mr_n_i(mr_n), .wd_fault_i(wd),
        .tmo_sel_i(sel), .rst_n_o(od_d), .rst_oe_o(od_oe), .rst_active_o(od_act));

    // pull-up resolution of each pad
    wire pad_pp = pp_oe ? pp_d : 1'b1;
    wire pad_od = od_oe ? od_d : 1'b1;

    function automatic int tmo_of(input logic [1:0] s);
        case (s)
            2'd0: return T0;
            2'd1: return T1;
            2'd2: return T2;
            default: return T3;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: m_mode 0 idle, 1 holding, 2 stretching
    int m_mode = 1;
    int m_rem = 0;
    bit m_btn = 1'b1;     // filtered button level, 1 = released
    int m_run = 0;        // consecutive samples disagreeing with m_btn
    bit m_pipe[$] = '{1'b1, 1'b1};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_rem = 0; m_btn = 1'b1; m_run = 0;
            m_pipe = '{1'b1, 1'b1};
        end else begin
            bit lvl;
            bit seen;
            lvl = uv || !m_btn;
            if (m_mode == 1) begin
                if (!lvl) begin m_mode = 2; m_rem = tmo_of(sel); end
            end else if (m_mode == 2) begin
                if (lvl) m_mode = 1;
                else if (wd) m_rem = tmo_of(sel);
                else begin
                    m_rem--;
                    if (m_rem == 0) m_mode = 0;
                end
            end else begin
                if (lvl) m_mode = 1;
                else if (wd) begin m_mode = 2; m_rem = tmo_of(sel); end
            end
            seen = m_pipe[0];
            if (seen != m_btn) begin
                m_run++;
                if (m_run == FILT) begin m_btn = seen; m_run = 0; end
            end else m_run = 0;
            void'(m_pipe.pop_front());
            m_pipe.push_back(mr_n);
        end
    end

    always @(negedge clk) begin
        int ea;
        ea = (m_mode != 0) ? 1 : 0;
        check({cur_req, " active pp"}, int'(pp_act), ea);
        check({cur_req, " active od"}, int'(od_act), ea);
        check("R10 pp oe", int'(pp_oe), 1);
        check("R10 pp data", int'(pp_d), 1 - ea);
        check("R10 od data", int'(od_d), 0);
        check("R10 od oe", int'(od_oe), ea);
        check("R10 pad pp", int'(pad_pp), 1 - ea);
        check("R10 pad od", int'(pad_od), 1 - ea);
    end

    // count negedge samples with reset active, starting after the next edge
    task automatic count_run(input bit drop_wd, output int n);
        n = 0;
        @(negedge clk);
        if (drop_wd) wd = 1'b0;
        while (pp_act) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_wait(input int c);
        repeat (c) @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual %0d expected <= 100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit rose;
        idle_wait(4);
        check("R1 reset active", int'(pp_act), 1);
        check("R1 reset pad", int'(pad_od), 0);

        // R1: first release follows a full timeout; R11 filter starts released
        cur_req = "R1";
        rst_n = 1'b1;
        count_run(1'b0, n);
        check("R1 first stretch", n, T0);
        idle_wait(3);

        // R2 / R5
        cur_req = "R2";
        sel = 2'd1;
        uv = 1'b1;
        @(negedge clk);
        check("R2 uv asserts", int'(pp_act), 1);
        idle_wait(10);
        check("R2 uv held", int'(pp_act), 1);
        cur_req = "R5";
        uv = 1'b0;
        count_run(1'b0, n);
        check("R5 stretch after uv", n, T1);
        idle_wait(3);

        // R9: every select code
        cur_req = "R9";
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            uv = 1'b1;
            idle_wait(3);
            uv = 1'b0;
            count_run(1'b0, n);
            check($sformatf("R9 sel %0d", s), n, tmo_of(2'(s)));
            idle_wait(2);
        end

        // R6: fault pulse in idle
        cur_req = "R6";
        sel = 2'd2;
        wd = 1'b1;
        count_run(1'b1, n);
        check("R6 fault stretch", n, T2);
        idle_wait(3);

        // R7: fault during stretch restarts it
        cur_req = "R7";
        sel = 2'd0;
        uv = 1'b1;
        idle_wait(2);
        uv = 1'b0;
        idle_wait(5);
        wd = 1'b1;
        count_run(1'b1, n);
        check("R7 restarted stretch", n, T0);
        idle_wait(3);

        // R8: level cause returns mid-stretch
        cur_req = "R8";
        uv = 1'b1;
        idle_wait(2);
        uv = 1'b0;
        idle_wait(4);
        uv = 1'b1;
        idle_wait(3);
        check("R8 back in hold", int'(pp_act), 1);
        uv = 1'b0;
        count_run(1'b0, n);
        check("R8 full stretch again", n, T0);
        idle_wait(3);

        // R4: short press ignored
        cur_req = "R4";
        rose = 1'b0;
        mr_n = 1'b0;
        idle_wait(FILT - 1);
        mr_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pp_act) rose = 1'b1;
        end
        check("R4 short press ignored", int'(rose), 0);

        // R3: press of exactly FILT cycles latency
        cur_req = "R3";
        mr_n = 1'b0;
        idle_wait(FILT + 2);
        check("R3 not yet", int'(pp_act), 0);
        @(negedge clk);
        check("R3 asserted", int'(pp_act), 1);

        // R11: bounce during press, then release stretch
        cur_req = "R11";
        idle_wait(5);
        mr_n = 1'b1;
        idle_wait(3);
        mr_n = 1'b0;
        idle_wait(FILT + 4);
        check("R11 bounce ignored", int'(pp_act), 1);
        mr_n = 1'b1;
        count_run(1'b0, n);
        check("R11 release stretch", n, FILT + 2 + T0);
        idle_wait(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule